// File: doc/BRIEF.md
# Interrupt Controller Command Sequencer

This block is the command and register side of a programmable eight-line interrupt controller. A byte-wide port with one address bit carries everything software does to the controller. The port accepts the initialization word sequence, the mode commands and the end-of-interrupt and rotation commands. The block holds the resulting state: the mask register, the in-service register, the rotation offset, the vector base and the mode flags. All of that state is driven out as plain pins for the neighbouring priority logic.

The request register and the line chosen by an external priority resolver come in as plain inputs. A read in poll mode acknowledges the resolver's winner and returns its number. Reads and writes are single-cycle strobes with no back-pressure: the port never stalls, a strobe is consumed on the clock edge where it is high, and read data is registered, so it appears one cycle after the read strobe and holds until the next read.

Top module: `irq_cmd_seq`

## Requirements
- R1: After reset, every register output is zero, the init step is 0 and no flag is set.
- R2: A write at address 0 with bit 4 set clears the mask, the in-service register, the offset, poll, special mask, auto-EOI and read select, moves to init step 1, and latches the fourth-word flag from bit 0, single mode from bit 1 and level mode from bit 3.
- R3: Address-1 writes step the init sequence. Step 1 loads the vector base as data AND 0xF8 and moves to step 3 (single with fourth word), to step 0 (single without it) or to step 2 (cascade). Step 2 moves to step 3 if the fourth word is needed, else to step 0. Step 3 latches nested mode from bit 4 and auto-EOI from bit 1 and returns to step 0.
- R4: An address-1 write in step 0 loads the mask register; in any other step the mask is left unchanged.
- R5: A write at address 0 with bit 4 clear and bit 3 set is a mode command: bit 2 arms poll, bit 1 set makes bit 0 the read select (1 in-service, 0 request), bit 6 set makes bit 5 the special-mask flag; a cleared enable bit leaves its flag unchanged.
- R6: Any other address-0 write takes its command code from bits 7:5. Code 0 clears and code 4 sets rotate-on-auto-EOI, and code 2 changes nothing.
- R7: Code 1 clears the highest-priority in-service bit, where line (offset + k) mod 8 ranks above line (offset + k + 1) mod 8; with the in-service register empty it does nothing.
- R8: Code 5 does what code 1 does and also sets the offset to the cleared line plus one, mod 8; with the in-service register empty the offset is unchanged.
- R9: Code 3 clears in-service bit data[2:0]; code 7 clears that bit and sets the offset to data[2:0] + 1 mod 8; code 6 sets the offset to data[2:0] + 1 mod 8.
- R10: A read while poll is armed and the resolver reports a winner n returns 0x80 | n one cycle later, pulses the acknowledge for one cycle with line n, and disarms poll. In-service bit n is set unless auto-EOI is on; with auto-EOI and rotate-on-auto-EOI on, the offset becomes n + 1 mod 8 instead.
- R11: A read while poll is armed and no winner is reported returns 0, gives no acknowledge and disarms poll.
- R12: A read with poll disarmed returns, one cycle later, the mask at address 1 and, at address 0, the in-service or request register as selected.
- R13: When write and read strobes are high together, the write is performed and the read is ignored: read data, poll state and the acknowledge do not change because of it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 1 | Register address bit |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_wdata | input | 8 | Write data |
| req_vec | input | 8 | Request register |
| win_valid | input | 1 | Resolver reports a winning line |
| win_line | input | 3 | Winning line number |
| rd_data | output | 8 | Registered read data |
| mask_reg | output | 8 | Mask register |
| isr_reg | output | 8 | In-service register |
| rot_offset | output | 3 | Rotation offset |
| vec_base | output | 8 | Vector base, low three bits zero |
| init_step | output | 2 | Init sequence step |
| level_mode | output | 1 | Level-trigger mode |
| single_mode | output | 1 | Single-controller mode |
| need_w4 | output | 1 | Fourth init word expected |
| nested_mode | output | 1 | Special fully nested mode |
| auto_eoi | output | 1 | Auto end-of-interrupt |
| rot_on_aeoi | output | 1 | Rotate on auto end-of-interrupt |
| special_mask | output | 1 | Special-mask flag |
| read_isr_sel | output | 1 | Address-0 read returns in-service register |
| poll_armed | output | 1 | Next read is a poll read |
| poll_ack | output | 1 | One-cycle acknowledge of a poll read |
| poll_line | output | 3 | Line acknowledged by the last poll |

## Verification
The init sequence runs in each of its four shapes: cascade with and without a fourth word, and single with and without one. These show that every step transition and the mask freeze during init are decoded from the latched flags. End-of-interrupt commands act on in-service patterns with several bits set, under offsets of 0, 2 and 6, so a non-rotated priority search or a wrong wrap gives a visibly different cleared bit. Poll reads are made with a winner, without one, under auto-EOI with and without rotation, and with the write strobe high at the same time. A behavioural model compares every output on every clock.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;
  localparam int DATA_W  = 8;
  localparam int N_LINES = 8;
  localparam int LINE_W  = $clog2(N_LINES);
  localparam int BASE_W  = DATA_W - LINE_W;

  typedef enum logic [1:0] {
    CK_OCW  = 2'd0,
    CK_MODE = 2'd1,
    CK_INIT = 2'd2
  } cmd_kind_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_BASE = 2'd1,
    ST_CASC = 2'd2,
    ST_MODE = 2'd3
  } init_step_e;

  localparam logic [2:0] OC_ROT_CLR  = 3'd0;
  localparam logic [2:0] OC_NS_EOI   = 3'd1;
  localparam logic [2:0] OC_NOP      = 3'd2;
  localparam logic [2:0] OC_SP_EOI   = 3'd3;
  localparam logic [2:0] OC_ROT_SET  = 3'd4;
  localparam logic [2:0] OC_NS_ROT   = 3'd5;
  localparam logic [2:0] OC_SET_OFF  = 3'd6;
  localparam logic [2:0] OC_SP_ROT   = 3'd7;
endpackage

// File: rtl/irq_cmd_decode.sv
module irq_cmd_decode
  import irq_seq_pkg::*;
(
  input  logic [DATA_W-1:0] wdata,
  output cmd_kind_e         kind,
  output logic [2:0]        code
);
  always_comb begin
    if (wdata[4])      kind = CK_INIT;
    else if (wdata[3]) kind = CK_MODE;
    else               kind = CK_OCW;
    code = wdata[DATA_W-1 -: 3];
  end
endmodule

// File: rtl/irq_rot_pick.sv
module irq_rot_pick
  import irq_seq_pkg::*;
(
  input  logic [N_LINES-1:0] vec,
  input  logic [LINE_W-1:0]  offset,
  output logic               hit,
  output logic [LINE_W-1:0]  line
);
  logic [LINE_W-1:0] idx;

  always_comb begin
    hit  = 1'b0;
    line = '0;
    idx  = '0;
    for (int k = N_LINES - 1; k >= 0; k--) begin
      idx = offset + LINE_W'(k);
      if (vec[idx]) begin
        hit  = 1'b1;
        line = idx;
      end
    end
  end
endmodule

// File: rtl/irq_init_fsm.sv
module irq_init_fsm
  import irq_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              load,
  input  logic [DATA_W-1:0] wdata,
  output init_step_e        step,
  output logic              single,
  output logic              need4,
  output logic              level,
  output logic [DATA_W-1:0] base,
  output logic              nested,
  output logic              aeoi
);
  logic [BASE_W-1:0] base_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      step   <= ST_IDLE;
      single <= 1'b0;
      need4  <= 1'b0;
      level  <= 1'b0;
      base_q <= '0;
      nested <= 1'b0;
      aeoi   <= 1'b0;
    end else if (start) begin
      step   <= ST_BASE;
      need4  <= wdata[0];
      single <= wdata[1];
      level  <= wdata[3];
      aeoi   <= 1'b0;
    end else if (load) begin
      unique case (step)
        ST_BASE: begin
          base_q <= wdata[DATA_W-1:LINE_W];
          if (single) step <= need4 ? ST_MODE : ST_IDLE;
          else        step <= ST_CASC;
        end
        ST_CASC: step <= need4 ? ST_MODE : ST_IDLE;
        ST_MODE: begin
          nested <= wdata[4];
          aeoi   <= wdata[1];
          step   <= ST_IDLE;
        end
        default: ;
      endcase
    end
  end

  assign base = {base_q, {LINE_W{1'b0}}};
endmodule

// File: rtl/irq_cmd_seq.sv
module irq_cmd_seq
  import irq_seq_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_addr,
  input  logic               reg_wr,
  input  logic               reg_rd,
  input  logic [DATA_W-1:0]  reg_wdata,
  input  logic [N_LINES-1:0] req_vec,
  input  logic               win_valid,
  input  logic [LINE_W-1:0]  win_line,
  output logic [DATA_W-1:0]  rd_data,
  output logic [N_LINES-1:0] mask_reg,
  output logic [N_LINES-1:0] isr_reg,
  output logic [LINE_W-1:0]  rot_offset,
  output logic [DATA_W-1:0]  vec_base,
  output logic [1:0]         init_step,
  output logic               level_mode,
  output logic               single_mode,
  output logic               need_w4,
  output logic               nested_mode,
  output logic               auto_eoi,
  output logic               rot_on_aeoi,
  output logic               special_mask,
  output logic               read_isr_sel,
  output logic               poll_armed,
  output logic               poll_ack,
  output logic [LINE_W-1:0]  poll_line
);
  cmd_kind_e         kind;
  logic [2:0]        code;
  init_step_e        step;
  logic              isr_hit;
  logic [LINE_W-1:0] isr_top;
  logic              wr0, wr1, rd_only;
  logic [LINE_W-1:0] arg_line;

  irq_cmd_decode u_dec (.wdata(reg_wdata), .kind(kind), .code(code));

  irq_rot_pick u_pick (.vec(isr_reg), .offset(rot_offset), .hit(isr_hit), .line(isr_top));

  assign wr0      = reg_wr && !reg_addr;
  assign wr1      = reg_wr && reg_addr;
  assign rd_only  = reg_rd && !reg_wr;
  assign arg_line = reg_wdata[LINE_W-1:0];

  irq_init_fsm u_init (
    .clk(clk), .rst_n(rst_n),
    .start(wr0 && kind == CK_INIT), .load(wr1), .wdata(reg_wdata),
    .step(step), .single(single_mode), .need4(need_w4), .level(level_mode),
    .base(vec_base), .nested(nested_mode), .aeoi(auto_eoi)
  );

  assign init_step = step;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_reg     <= '0;
      isr_reg      <= '0;
      rot_offset   <= '0;
      rot_on_aeoi  <= 1'b0;
      special_mask <= 1'b0;
      read_isr_sel <= 1'b0;
      poll_armed   <= 1'b0;
      poll_ack     <= 1'b0;
      poll_line    <= '0;
      rd_data      <= '0;
    end else begin
      poll_ack <= 1'b0;
      if (wr0) begin
        unique case (kind)
          CK_INIT: begin
            mask_reg     <= '0;
            isr_reg      <= '0;
            rot_offset   <= '0;
            poll_armed   <= 1'b0;
            special_mask <= 1'b0;
            read_isr_sel <= 1'b0;
          end
          CK_MODE: begin
            if (reg_wdata[2]) poll_armed   <= 1'b1;
            if (reg_wdata[1]) read_isr_sel <= reg_wdata[0];
            if (reg_wdata[6]) special_mask <= reg_wdata[5];
          end
          default: begin
            unique case (code)
              OC_ROT_CLR: rot_on_aeoi <= 1'b0;
              OC_ROT_SET: rot_on_aeoi <= 1'b1;
              OC_NS_EOI, OC_NS_ROT: begin
                if (isr_hit) begin
                  isr_reg[isr_top] <= 1'b0;
                  if (code == OC_NS_ROT) rot_offset <= isr_top + 1'b1;
                end
              end
              OC_SP_EOI: isr_reg[arg_line] <= 1'b0;
              OC_SET_OFF: rot_offset <= arg_line + 1'b1;
              OC_SP_ROT: begin
                isr_reg[arg_line] <= 1'b0;
                rot_offset        <= arg_line + 1'b1;
              end
              default: ;
            endcase
          end
        endcase
      end else if (wr1) begin
        if (step == ST_IDLE) mask_reg <= reg_wdata;
      end else if (rd_only) begin
        if (poll_armed) begin
          poll_armed <= 1'b0;
          if (win_valid) begin
            rd_data   <= {1'b1, {(DATA_W-LINE_W-1){1'b0}}, win_line};
            poll_ack  <= 1'b1;
            poll_line <= win_line;
            if (!auto_eoi)        isr_reg[win_line] <= 1'b1;
            else if (rot_on_aeoi) rot_offset <= win_line + 1'b1;
          end else begin
            rd_data <= '0;
          end
        end else if (reg_addr) begin
          rd_data <= mask_reg;
        end else begin
          rd_data <= read_isr_sel ? isr_reg : req_vec;
        end
      end
    end
  end
endmodule

// File: rtl/irq_cmd_seq_chk.sv
module irq_cmd_seq_chk
  import irq_seq_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               reg_addr,
  input logic               reg_wr,
  input logic               reg_rd,
  input logic [DATA_W-1:0]  reg_wdata,
  input logic               win_valid,
  input logic [LINE_W-1:0]  win_line,
  input logic [DATA_W-1:0]  rd_data,
  input logic [N_LINES-1:0] mask_reg,
  input logic [N_LINES-1:0] isr_reg,
  input logic [LINE_W-1:0]  rot_offset,
  input logic [1:0]         init_step,
  input logic               auto_eoi,
  input logic               poll_armed,
  input logic               poll_ack,
  input logic [LINE_W-1:0]  poll_line
);
  AST_INIT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && !reg_addr && reg_wdata[4]) |=> (mask_reg == '0 && isr_reg == '0 && rot_offset == '0 && init_step == 2'd1)); // R2
  AST_MODE_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr && init_step == 2'd3) |=> (init_step == 2'd0)); // R3
  AST_MASK_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr && init_step != 2'd0) |=> $stable(mask_reg)); // R4
  AST_POLL_DISARM: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && !reg_wr && poll_armed) |=> !poll_armed); // R10
  AST_POLL_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    poll_ack |-> (rd_data == {1'b1, {(DATA_W-LINE_W-1){1'b0}}, poll_line})); // R10
  AST_ISR_ON_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && !reg_wr && poll_armed && win_valid && !auto_eoi) |=> isr_reg[$past(win_line)]); // R10
  AST_NO_ACK_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && !reg_wr && poll_armed && !win_valid) |=> (!poll_ack && rd_data == '0)); // R11
  AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |=> ($stable(rd_data) && !poll_ack)); // R13
endmodule

bind irq_cmd_seq irq_cmd_seq_chk i_chk (
  .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
  .reg_wdata(reg_wdata), .win_valid(win_valid), .win_line(win_line), .rd_data(rd_data),
  .mask_reg(mask_reg), .isr_reg(isr_reg), .rot_offset(rot_offset), .init_step(init_step),
  .auto_eoi(auto_eoi), .poll_armed(poll_armed), .poll_ack(poll_ack), .poll_line(poll_line)
);

// File: tb/test_irq_cmd_seq.sv
module test_irq_cmd_seq;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_addr = 1'b0, reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0] reg_wdata = '0, req_vec = '0;
  logic       win_valid = 1'b0;
  logic [2:0] win_line = '0;
  logic [7:0] rd_data, mask_reg, isr_reg, vec_base;
  logic [2:0] rot_offset, poll_line;
  logic [1:0] init_step;
  logic level_mode, single_mode, need_w4, nested_mode, auto_eoi, rot_on_aeoi;
  logic special_mask, read_isr_sel, poll_armed, poll_ack;

  int checks = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_cmd_seq i_irq_cmd_seq (.*);

  // behavioural reference model
  int m_mask, m_isr, m_off, m_step, m_base, m_single, m_need4, m_level, m_nested;
  int m_aeoi, m_rot, m_poll, m_smm, m_rsel, m_rd, m_ack, m_ackline;

  function automatic int top_isr(int isr, int off);
    for (int k = 0; k < 8; k++) if (isr & (1 << ((off + k) % 8))) return (off + k) % 8;
    return -1;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_mask = 0; m_isr = 0; m_off = 0; m_step = 0; m_base = 0; m_single = 0; m_need4 = 0;
      m_level = 0; m_nested = 0; m_aeoi = 0; m_rot = 0; m_poll = 0; m_smm = 0; m_rsel = 0;
      m_rd = 0; m_ack = 0; m_ackline = 0;
    end else begin
      int d, c, t;
      d = reg_wdata;
      m_ack = 0;
      if (reg_wr && !reg_addr) begin
        if (d & 16) begin
          m_mask = 0; m_isr = 0; m_off = 0; m_poll = 0; m_smm = 0; m_rsel = 0; m_aeoi = 0;
          m_step = 1; m_need4 = d & 1; m_single = (d >> 1) & 1; m_level = (d >> 3) & 1;
        end else if (d & 8) begin
          if (d & 4) m_poll = 1;
          if (d & 2) m_rsel = d & 1;
          if (d & 64) m_smm = (d >> 5) & 1;
        end else begin
          c = d >> 5;
          if (c == 0) m_rot = 0;
          if (c == 4) m_rot = 1;
          if (c == 1 || c == 5) begin
            t = top_isr(m_isr, m_off);
            if (t >= 0) begin
              m_isr = m_isr & ~(1 << t);
              if (c == 5) m_off = (t + 1) % 8;
            end
          end
          if (c == 3 || c == 7) m_isr = m_isr & ~(1 << (d % 8));
          if (c == 6 || c == 7) m_off = (d + 1) % 8;
        end
      end else if (reg_wr) begin
        if (m_step == 0) m_mask = d;
        else if (m_step == 1) begin
          m_base = d & 248;
          m_step = m_single ? (m_need4 ? 3 : 0) : 2;
        end else if (m_step == 2) m_step = m_need4 ? 3 : 0;
        else begin
          m_nested = (d >> 4) & 1; m_aeoi = (d >> 1) & 1; m_step = 0;
        end
      end else if (reg_rd) begin
        if (m_poll) begin
          m_poll = 0;
          if (win_valid) begin
            m_rd = 128 + win_line; m_ack = 1; m_ackline = win_line;
            if (!m_aeoi) m_isr = m_isr | (1 << win_line);
            else if (m_rot) m_off = (win_line + 1) % 8;
          end else m_rd = 0;
        end else if (reg_addr) m_rd = m_mask;
        else m_rd = m_rsel ? m_isr : req_vec;
      end
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      chk("R4 mask", mask_reg, m_mask);
      chk("R7 isr", isr_reg, m_isr);
      chk("R8 offset", rot_offset, m_off);
      chk("R3 step", init_step, m_step);
      chk("R3 base", vec_base, m_base);
      chk("R2 flags", {level_mode, single_mode, need_w4}, {m_level[0], m_single[0], m_need4[0]});
      chk("R3 nested/aeoi", {nested_mode, auto_eoi}, {m_nested[0], m_aeoi[0]});
      chk("R5 mode flags", {poll_armed, special_mask, read_isr_sel}, {m_poll[0], m_smm[0], m_rsel[0]});
      chk("R6 rot_on_aeoi", rot_on_aeoi, m_rot);
      chk("R12 rd_data", rd_data, m_rd);
      chk("R10 poll_ack", poll_ack, m_ack);
      if (poll_ack) chk("R10 poll_line", poll_line, m_ackline);
    end
  end

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic a);
    @(negedge clk); reg_addr = a; reg_rd = 1'b1;
    @(negedge clk); reg_rd = 1'b0;
  endtask

  task automatic poll_line_n(input logic [2:0] n);
    win_valid = 1'b1; win_line = n;
    wr(1'b0, 8'h0C);
    rd(1'b0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset mask", mask_reg, 0);
    chk("R1 reset isr", isr_reg, 0);
    chk("R1 reset step", init_step, 0);
    chk("R1 reset rd", rd_data, 0);
    rst_n = 1'b1;

    // cascade, fourth word
    wr(0, 8'h11);  chk("R2 step1", init_step, 1); chk("R2 need4", need_w4, 1);
    wr(1, 8'h45);  chk("R3 base", vec_base, 8'h40); chk("R3 to step2", init_step, 2);
    wr(1, 8'h04);  chk("R3 to step3", init_step, 3);
    wr(1, 8'h12);  chk("R3 nested+aeoi", {nested_mode, auto_eoi}, 2'b11); chk("R3 to step0", init_step, 0);
    wr(1, 8'hA5);  rd(1); chk("R12 mask read", rd_data, 8'hA5);
    // single, fourth word
    wr(0, 8'h13);  chk("R2 mask cleared", mask_reg, 0); chk("R2 aeoi cleared", auto_eoi, 0);
    wr(1, 8'h20);  chk("R3 single->step3", init_step, 3);
    wr(1, 8'h00);
    // single, no fourth word
    wr(0, 8'h12);  wr(1, 8'h08); chk("R3 single->step0", init_step, 0);
    // cascade, no fourth word; mask frozen during init
    wr(0, 8'h10);  wr(1, 8'h77); chk("R4 mask frozen", mask_reg, 0); chk("R3 base 70", vec_base, 8'h70);
    wr(1, 8'h00);  chk("R3 casc->step0", init_step, 0);

    // poll reads with winners
    poll_line_n(3'd5);
    chk("R10 poll data", rd_data, 8'h85); chk("R10 ack", poll_ack, 1); chk("R10 disarm", poll_armed, 0);
    chk("R10 isr set", isr_reg, 8'h20);
    poll_line_n(3'd2); poll_line_n(3'd7);
    chk("R10 isr three", isr_reg, 8'hA4);
    wr(0, 8'h20);  chk("R7 eoi offset0", isr_reg, 8'hA0);
    wr(0, 8'hC5);  chk("R9 set offset", rot_offset, 6);
    wr(0, 8'h20);  chk("R7 eoi rotated", isr_reg, 8'h20);
    wr(0, 8'hA0);  chk("R8 rot eoi isr", isr_reg, 0); chk("R8 rot eoi off", rot_offset, 6);
    wr(0, 8'hA0);  chk("R8 empty keeps off", rot_offset, 6);
    // poll without winner
    win_valid = 1'b0;
    wr(0, 8'h0C); rd(0);
    chk("R11 empty data", rd_data, 0); chk("R11 no ack", poll_ack, 0); chk("R11 disarm", poll_armed, 0);
    // specific commands
    poll_line_n(3'd3); poll_line_n(3'd1);
    chk("R10 isr 0A", isr_reg, 8'h0A);
    wr(0, 8'h63);  chk("R9 specific eoi", isr_reg, 8'h02);
    wr(0, 8'hE1);  chk("R9 specific rot isr", isr_reg, 0); chk("R9 specific rot off", rot_offset, 2);
    // rotate-on-aeoi codes and the no-op code
    wr(0, 8'h80);  chk("R6 rot set", rot_on_aeoi, 1);
    poll_line_n(3'd0);
    wr(0, 8'h47);  chk("R6 nop isr", isr_reg, 8'h01); chk("R6 nop off", rot_offset, 2); chk("R6 nop rot", rot_on_aeoi, 1);
    wr(0, 8'h00);  chk("R6 rot clr", rot_on_aeoi, 0);
    wr(0, 8'h20);  chk("R7 eoi wrap", isr_reg, 0);
    // readback select and special mask
    req_vec = 8'h3C;
    wr(0, 8'h0A); rd(0); chk("R12 req read", rd_data, 8'h3C);
    poll_line_n(3'd6);
    wr(0, 8'h0B); rd(0); chk("R12 isr read", rd_data, 8'h40);
    wr(0, 8'h08); rd(0); chk("R5 sel kept", rd_data, 8'h40);
    wr(0, 8'h68); chk("R5 smm set", special_mask, 1);
    wr(0, 8'h28); chk("R5 smm kept", special_mask, 1);
    wr(0, 8'h48); chk("R5 smm clr", special_mask, 0);
    // auto-EOI polls
    wr(0, 8'h13); wr(1, 8'h20); wr(1, 8'h02);
    wr(0, 8'h80);
    poll_line_n(3'd4);
    chk("R10 aeoi isr", isr_reg, 0); chk("R10 aeoi rot off", rot_offset, 5); chk("R10 aeoi data", rd_data, 8'h84);
    wr(0, 8'h00);
    poll_line_n(3'd6);
    chk("R10 aeoi norot off", rot_offset, 5); chk("R10 aeoi norot isr", isr_reg, 0);
    // write and read together
    wr(0, 8'h0C);
    @(negedge clk); reg_addr = 1'b1; reg_wdata = 8'h5A; reg_wr = 1'b1; reg_rd = 1'b1;
    @(negedge clk); reg_wr = 1'b0; reg_rd = 1'b0;
    chk("R13 mask written", mask_reg, 8'h5A); chk("R13 poll kept", poll_armed, 1);
    chk("R13 rd held", rd_data, 8'h86); chk("R13 no ack", poll_ack, 0);
    rd(1); chk("R10 late poll", rd_data, 8'h86);
    // level mode latch
    wr(0, 8'h18); chk("R2 level", level_mode, 1);
    wr(1, 8'h00); wr(1, 8'h00); chk("R3 level seq done", init_step, 0);

    repeat (2) @(negedge clk);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule